// File: doc/BRIEF.md
# Converter Bus Controller

This block drives a parallel-bus sampling converter whose strobes are all active low: chip select, start (write), read and a completion interrupt. When the host raises a one-cycle request, the controller sends a start pulse with chip select held low. It then waits for the conversion to finish. In interrupt mode it waits for the converter's interrupt line to fall. In fixed-delay mode it counts a fixed number of system clocks. It then runs a read strobe that is stretched by a programmable number of wait cycles. At the end of that strobe it latches the 8-bit data and presents it with a one-cycle valid pulse.

The controller also has a free-running setting. In that setting chip select and read are held low, and the converter's interrupt output is passed straight back to its write input. Because that loop needs a first start, the write line is held low for a short time after reset. Each completed conversion is captured without any host request.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset in host mode, chip select, write and read are all high, and busy, valid and the timeout error are all low.
- R2: A request taken while idle makes the controller drive write low and chip select low together for max(start_width, 1) system clocks. After that, both lines return high.
- R3: In interrupt mode, the read strobe starts only after a falling edge of the interrupt input has been seen since the start pulse. It begins three clocks after that edge, with no fixed-delay wait.
- R4: In fixed-delay mode, the read strobe falls no earlier than CONV_CLKS*CLK_DIV system clocks (default 74*4 = 296) after the write line rises.
- R5: A read holds read low and chip select low together for rd_wait+1 system clocks. Write and read are never low at the same time outside free-running mode.
- R6: The data byte present at the end of the read strobe is loaded into result, and result_valid pulses high for exactly one cycle. At all other times result does not change.
- R7: In interrupt mode, if no interrupt edge arrives within tmo_limit clocks of waiting, the controller sets tmo_err, returns to idle with all strobes high and leaves result and result_valid untouched. The next accepted request clears tmo_err.
- R8: A request that arrives while the controller waits for completion starts a new start pulse. It takes priority over a completion seen in the same cycle. The abandoned conversion never produces a valid pulse.
- R9: With free_run high, chip select and read are low, and the write output equals the interrupt input once the start-up period has ended.
- R10: With free_run high through reset, the write line stays low for KICK_CYC clocks counted from reset release (default 4). These are the sample points at reset release and after each of the first KICK_CYC-1 clock edges.
- R11: In free-running mode, every falling edge of the interrupt captures the data bus into result with a one-cycle valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle sample request from the host |
| mode_irq | input | 1 | 1: wait for the interrupt, 0: wait a fixed delay |
| free_run | input | 1 | 1: free-running loop mode |
| start_width | input | PW | Start pulse low width in clocks (0 treated as 1) |
| rd_wait | input | PW | Extra wait cycles on the read strobe |
| tmo_limit | input | CNT_W | Interrupt-mode timeout in clocks |
| conv_cs_n | output | 1 | Converter chip select, active low |
| conv_wr_n | output | 1 | Converter start strobe, active low |
| conv_rd_n | output | 1 | Converter read strobe, active low |
| conv_intr_n | input | 1 | Converter completion interrupt, active low |
| conv_data | input | DW | Converter data bus |
| result | output | DW | Last captured byte |
| result_valid | output | 1 | One-cycle pulse when result updates |
| busy | output | 1 | Host sequence in progress |
| tmo_err | output | 1 | Interrupt timeout flag |

## Verification
The critical collision is a new host request landing in the same clock in which the synchronized interrupt edge is first seen. At that clock the controller could either begin the read or restart the converter. The bench provokes this by watching the interrupt pin fall, counting the synchronizer delay, and then raising the request for exactly the clock in which the edge reaches the state machine. The test passes only if the bench sees two start pulses, a single valid pulse, and a result that equals the byte from the restarted conversion rather than the first one.

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int DW        = 8,
  parameter int PW        = 8,
  parameter int CNT_W     = 16,
  parameter int CONV_CLKS = 74,
  parameter int CLK_DIV   = 4,
  parameter int KICK_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             mode_irq,
  input  logic             free_run,
  input  logic [PW-1:0]    start_width,
  input  logic [PW-1:0]    rd_wait,
  input  logic [CNT_W-1:0] tmo_limit,
  output logic             conv_cs_n,
  output logic             conv_wr_n,
  output logic             conv_rd_n,
  input  logic             conv_intr_n,
  input  logic [DW-1:0]    conv_data,
  output logic [DW-1:0]    result,
  output logic             result_valid,
  output logic             busy,
  output logic             tmo_err
);

  localparam int FIX_CYC = CONV_CLKS * CLK_DIV;
  localparam int KW      = (KICK_CYC > 0) ? $clog2(KICK_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] FIX_LAST = CNT_W'(FIX_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT, S_READ} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       isync;
  logic [KW-1:0]    kick;

  wire intr_fall  = isync[2] & ~isync[1];
  wire start_done = (cnt + CNT_W'(1)) >= CNT_W'(start_width);
  wire rd_done    = cnt >= CNT_W'(rd_wait);
  wire tmo_hit    = (cnt + CNT_W'(1)) >= tmo_limit;
  wire fix_done   = cnt >= FIX_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isync <= '1;
      kick  <= KW'(KICK_CYC);
    end else begin
      isync <= {isync[1:0], conv_intr_n};
      if (kick != '0) kick <= kick - KW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      tmo_err      <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (free_run) begin
        st  <= S_IDLE;
        cnt <= '0;
        if (intr_fall) begin
          result       <= conv_data;
          result_valid <= 1'b1;
        end
      end else begin
        unique case (st)
          S_IDLE: if (req) begin
            tmo_err <= 1'b0;
            cnt     <= '0;
            st      <= S_START;
          end
          S_START: begin
            if (start_done) begin
              cnt <= '0;
              st  <= S_WAIT;
            end else cnt <= cnt + CNT_W'(1);
          end
          S_WAIT: begin
            if (req) begin
              cnt <= '0;
              st  <= S_START;
            end else if (mode_irq) begin
              if (intr_fall) begin
                cnt <= '0;
                st  <= S_READ;
              end else if (tmo_hit) begin
                tmo_err <= 1'b1;
                cnt     <= '0;
                st      <= S_IDLE;
              end else cnt <= cnt + CNT_W'(1);
            end else begin
              if (fix_done) begin
                cnt <= '0;
                st  <= S_READ;
              end else cnt <= cnt + CNT_W'(1);
            end
          end
          S_READ: begin
            if (rd_done) begin
              result       <= conv_data;
              result_valid <= 1'b1;
              cnt          <= '0;
              st           <= S_IDLE;
            end else cnt <= cnt + CNT_W'(1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign conv_cs_n = free_run ? 1'b0 : !(st == S_START || st == S_READ);
  assign conv_rd_n = free_run ? 1'b0 : (st != S_READ);
  assign conv_wr_n = free_run ? ((kick != '0) ? 1'b0 : conv_intr_n) : (st != S_START);

endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          free_run,
  input logic          conv_cs_n,
  input logic          conv_wr_n,
  input logic          conv_rd_n,
  input logic [DW-1:0] result,
  input logic          result_valid,
  input logic          busy,
  input logic          tmo_err
);

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && !busy) |-> (conv_cs_n && conv_wr_n && conv_rd_n)); // R1

  AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && !conv_wr_n) |-> !conv_cs_n); // R2

  AST_NO_WR_RD_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !free_run |-> (conv_wr_n || conv_rd_n)); // R5

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result)); // R6

  AST_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && $rose(tmo_err)) |-> (!result_valid && conv_cs_n && !busy)); // R7

  AST_FREE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    free_run |-> (!conv_cs_n && !conv_rd_n && !busy)); // R9

endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .free_run(free_run),
  .conv_cs_n(conv_cs_n), .conv_wr_n(conv_wr_n), .conv_rd_n(conv_rd_n),
  .result(result), .result_valid(result_valid), .busy(busy), .tmo_err(tmo_err)
);

// File: tb/adc_bus_ctrl_tb_top.sv
module adc_bus_ctrl_tb_top;
  localparam int DW = 8, PW = 8, CNT_W = 16;
  localparam int CONV_CLKS = 74, CLK_DIV = 4, KICK_CYC = 4;
  localparam int FIX_CYC = CONV_CLKS * CLK_DIV;
  localparam int CONV_T  = 200;

  logic clk = 0, rst_n = 0, req = 0, mode_irq = 0, free_run = 0;
  logic [PW-1:0] start_width = 1, rd_wait = 0;
  logic [CNT_W-1:0] tmo_limit = 1000;
  logic conv_cs_n, conv_wr_n, conv_rd_n, result_valid, busy, tmo_err;
  logic conv_intr_n;
  logic [DW-1:0] conv_data, result;

  always #4 clk = ~clk;

  adc_bus_ctrl #(.DW(DW), .PW(PW), .CNT_W(CNT_W), .CONV_CLKS(CONV_CLKS),
                 .CLK_DIV(CLK_DIV), .KICK_CYC(KICK_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .mode_irq(mode_irq), .free_run(free_run),
    .start_width(start_width), .rd_wait(rd_wait), .tmo_limit(tmo_limit),
    .conv_cs_n(conv_cs_n), .conv_wr_n(conv_wr_n), .conv_rd_n(conv_rd_n),
    .conv_intr_n(conv_intr_n), .conv_data(conv_data), .result(result),
    .result_valid(result_valid), .busy(busy), .tmo_err(tmo_err));

  // converter model
  logic m_intr_n = 1, m_busy = 0, m_armed = 0, m_pw = 1, m_pr = 1, m_suppress = 0;
  logic [DW-1:0] m_latch = 0, m_done = 0, m_pend = 0;
  int m_cnt = 0;
  assign conv_intr_n = m_intr_n;
  assign conv_data   = m_latch;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_intr_n <= 1; m_busy <= 0; m_armed <= 0; m_pw <= 1; m_pr <= 1;
    end else begin
      m_pw <= conv_wr_n;
      m_pr <= conv_rd_n;
      if (m_pw && !conv_wr_n && !conv_cs_n) begin
        m_armed <= 1; m_busy <= 0; m_intr_n <= 1;
      end else if (!m_pw && conv_wr_n && m_armed) begin
        m_armed <= 0; m_busy <= 1; m_cnt <= CONV_T; m_pend <= DW'($urandom);
      end else if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy <= 0; m_latch <= m_pend; m_done <= m_pend;
          if (!m_suppress) m_intr_n <= 0;
        end else m_cnt <= m_cnt - 1;
      end
      if (m_pr && !conv_rd_n && !conv_cs_n) m_intr_n <= 1;
    end
  end

  // bus monitor
  int cyc = 0, wr_w = 0, last_wr_w = 0, rd_w = 0, last_rd_w = 0;
  int t_wr_rise = 0, t_rd_fall = 0, vcount = 0, wr_rises = 0;
  bit wr_cs_bad = 0, rd_cs_bad = 0, intr_fell = 0, rd_intr_seen = 0, prev_intr = 1;

  always begin
    @(negedge clk); #1;
    cyc++;
    if (!conv_wr_n) begin
      wr_w++; intr_fell = 0;
      if (conv_cs_n) wr_cs_bad = 1;
    end else if (wr_w != 0) begin
      last_wr_w = wr_w; wr_w = 0; t_wr_rise = cyc; wr_rises++;
    end
    if (prev_intr && !conv_intr_n) intr_fell = 1;
    prev_intr = conv_intr_n;
    if (!conv_rd_n) begin
      if (rd_w == 0) begin t_rd_fall = cyc; rd_intr_seen = intr_fell; end
      rd_w++;
      if (conv_cs_n) rd_cs_bad = 1;
    end else if (rd_w != 0) begin
      last_rd_w = rd_w; rd_w = 0;
    end
    if (result_valid) vcount++;
  end

  int n_tests = 0, n_fail = 0, wd = 0;
  bit finished = 0;

  function automatic int exp_wr(input int sw);
    return (sw == 0) ? 1 : sw;
  endfunction
  function automatic int exp_rd(input int rw);
    return rw + 1;
  endfunction

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk); #1;
  endtask

  task automatic wait_valid(output bit got, input int lim);
    got = 0;
    for (int i = 0; i < lim && !got; i++) begin
      tick;
      if (result_valid) got = 1;
    end
  endtask

  task automatic pulse_req;
    req = 1; tick; req = 0;
  endtask

  task automatic do_conv(input bit irq, input int sw, input int rw);
    bit got; int v0, gap;
    mode_irq = irq; start_width = PW'(sw); rd_wait = PW'(rw); tmo_limit = 1000;
    wr_cs_bad = 0; rd_cs_bad = 0; v0 = vcount;
    pulse_req;
    wait_valid(got, 2000);
    tick;
    chk(got, "R6", "valid seen", int'(got), 1);
    chk(result == m_done, "R6", "result byte", result, m_done);
    chk(vcount - v0 == 1, "R6", "valid pulses", vcount - v0, 1);
    chk(last_wr_w == exp_wr(sw), "R2", "start width", last_wr_w, exp_wr(sw));
    chk(!wr_cs_bad, "R2", "cs low during start", int'(wr_cs_bad), 0);
    chk(last_rd_w == exp_rd(rw), "R5", "read width", last_rd_w, exp_rd(rw));
    chk(!rd_cs_bad, "R5", "cs low during read", int'(rd_cs_bad), 0);
    chk(tmo_err == 0, "R7", "no timeout", tmo_err, 0);
    gap = t_rd_fall - t_wr_rise;
    if (irq) begin
      chk(rd_intr_seen, "R3", "interrupt before read", int'(rd_intr_seen), 1);
      chk(gap == CONV_T + 4, "R3", "read after interrupt", gap, CONV_T + 4);
    end else begin
      chk(gap >= FIX_CYC, "R4", "fixed delay gap", gap, FIX_CYC);
    end
    for (int i = 0; i < 4; i++) tick;
    chk(vcount - v0 == 1 && result == m_done, "R6", "result held", vcount - v0, 1);
  endtask

  initial begin
    bit got; int v0, r0, w0, k;
    void'($urandom(32'd20240));
    for (int i = 0; i < 4; i++) tick;
    rst_n = 1;
    tick;
    chk(conv_cs_n && conv_wr_n && conv_rd_n, "R1", "strobes idle high",
        {conv_cs_n, conv_wr_n, conv_rd_n}, 7);
    chk(!busy && !result_valid && !tmo_err, "R1", "flags low",
        {busy, result_valid, tmo_err}, 0);

    // directed corners
    do_conv(1, 3, 2);
    do_conv(0, 0, 0);
    do_conv(1, 1, 5);
    do_conv(0, 7, 3);

    // random mix
    for (int i = 0; i < 16; i++)
      do_conv(1'($urandom % 2), int'($urandom % 7), int'($urandom % 6));

    // timeout (R7)
    m_suppress = 1; mode_irq = 1; tmo_limit = 50; start_width = 2;
    r0 = result; v0 = vcount; k = 0;
    pulse_req;
    while (!tmo_err && k < 600) begin tick; k++; end
    chk(tmo_err == 1, "R7", "timeout flagged", tmo_err, 1);
    chk(k >= 50 && k <= 56, "R7", "timeout delay", k, 51);
    chk(vcount == v0 && result == r0, "R7", "result untouched", result, r0);
    chk(conv_cs_n && conv_wr_n && conv_rd_n && !busy, "R7", "idle after timeout",
        {conv_cs_n, conv_wr_n, conv_rd_n}, 7);
    for (int i = 0; i < CONV_T + 10; i++) tick;
    m_suppress = 0;
    chk(tmo_err == 1, "R7", "flag held until request", tmo_err, 1);
    do_conv(1, 2, 1);

    // restart while waiting (R8)
    mode_irq = 0; start_width = 2; rd_wait = 1; v0 = vcount; w0 = wr_rises;
    pulse_req;
    for (int i = 0; i < 30; i++) tick;
    pulse_req;
    wait_valid(got, 2000); tick;
    chk(vcount - v0 == 1, "R8", "single valid after restart", vcount - v0, 1);
    chk(wr_rises - w0 == 2, "R8", "two start pulses", wr_rises - w0, 2);
    chk(result == m_done, "R8", "result from restarted conversion", result, m_done);

    // request in the same cycle as completion (R8)
    mode_irq = 1; tmo_limit = 1000; v0 = vcount; w0 = wr_rises; k = 0;
    pulse_req;
    while (conv_intr_n && k < 1000) begin tick; k++; end
    r0 = m_done;
    tick; tick;
    req = 1; tick; req = 0;
    wait_valid(got, 2000); tick;
    chk(vcount - v0 == 1, "R8", "restart beats completion valid count", vcount - v0, 1);
    chk(wr_rises - w0 == 2, "R8", "restart beats completion starts", wr_rises - w0, 2);
    chk(result == m_done && result != r0, "R8", "byte from new conversion", result, m_done);

    // free-running (R9, R10, R11)
    free_run = 1; rst_n = 0;
    for (int i = 0; i < 3; i++) tick;
    rst_n = 1; k = 0;
    while (!conv_wr_n && k < 100) begin k++; tick; end
    chk(k == KICK_CYC, "R10", "start-up write low length", k, KICK_CYC);
    for (int n = 0; n < 3; n++) begin
      wait_valid(got, 1000);
      chk(got, "R11", "free-run valid", int'(got), 1);
      chk(result == m_done, "R11", "free-run byte", result, m_done);
      tick;
      chk(!conv_cs_n && !conv_rd_n, "R9", "cs and rd low", {conv_cs_n, conv_rd_n}, 0);
      chk(conv_wr_n == conv_intr_n, "R9", "write follows interrupt", conv_wr_n, conv_intr_n);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule